// File: doc/BRIEF.md
# Vector Loop State Register Unit

This unit holds one 64-bit architectural word that acts as a sub-program-counter for vector loops. The word carries the maximum vector length (MVL), the current vector length (VL), the source and destination element steps, the subvector steps, the remap selector and enable fields, a parallelism hint, a remap-persist bit and a vertical-first mode bit. The surrounding pipeline issues requests to the unit: set the length, advance by one executed element, take an explicit step, enter or return from an exception, swap with a link copy, or write the whole word.

The unit checks every write and length request for range. It caps VL at MVL, sequences the step counters, and pulses a done flag when a loop wraps. It keeps a save copy and a link copy that are exchanged with the live word in one cycle. A vector-active flag is low whenever the live word is all zero.

Top module: `vls_core`

## Requirements
- R1: Word layout, with vector bit 63 as the most significant bit: maxvl [63:57], vl [56:50], srcstep [49:43], dststep [42:36], dsubstep [35:34], ssubstep [33:32], remap selectors [31:22], remap enable [21:17], reserved [16:9], hint [8:2], persist [1], vertical-first [0].
- R2: A set-length request with an MVL operand of 1 to 64 stores MVL, sets VL to the smaller of the requested length and MVL, and clears both element steps and both subvector steps.
- R3: A legal full-word write whose vl field is larger than its maxvl field stores VL equal to MVL. Otherwise the word is stored as written.
- R4: A write with srcstep or dststep of 64 or more, or with vl or maxvl above 64, or a set-length request with MVL 0 or above 64, leaves the word unchanged and raises illegal_o for one cycle on the following cycle.
- R5: An advance with subvl outside 1 to 4 leaves the word unchanged and raises illegal_o for one cycle on the following cycle.
- R6: When vertical-first is 1, only step_req advances and elem_adv has no effect. When it is 0, only elem_adv advances and step_req has no effect.
- R7: An advance with VL nonzero does the following. If dsubstep equals subvl-1, both substeps go to 0. Then, if dststep equals VL-1, both element steps go to 0 and done_o pulses on the following cycle; otherwise both element steps increment. If dsubstep does not equal subvl-1, both substeps are set to dsubstep+1. An advance with VL zero changes nothing.
- R8: A successful set-length request clears the persist bit if the new VL or the new MVL differs from the old one, and keeps it otherwise.
- R9: active_o is 0 exactly when the live word is all zero.
- R10: exc_enter copies the live word into the save register and leaves the live word unchanged. exc_return copies the save register into the live word.
- R11: link_swap exchanges the live word and the link register in one cycle.
- R12: When requests coincide, priority runs exc_enter, exc_return, link_swap, write, set-length, advance. Only the highest one takes effect.
- R13: After reset the live, save and link registers are zero and illegal_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Full-word write request |
| wr_data | input | 64 | Word to write |
| setvl_en | input | 1 | Set-length request |
| setvl_len | input | 8 | Requested vector length |
| setvl_mvl | input | 7 | New maximum vector length |
| elem_adv | input | 1 | One element executed (horizontal mode) |
| step_req | input | 1 | Explicit step request (vertical-first mode) |
| subvl | input | 3 | Subvector length for the advance |
| exc_enter | input | 1 | Exception entry: save the live word |
| exc_return | input | 1 | Exception return: restore the live word |
| link_swap | input | 1 | Exchange the live word with the link copy |
| state_o | output | 64 | Live word |
| save_o | output | 64 | Save register |
| link_o | output | 64 | Link register |
| illegal_o | output | 1 | Illegal-request pulse |
| done_o | output | 1 | Loop-complete pulse |
| active_o | output | 1 | Vector mode active |

## Verification
The assertions assume that every input has a known 0 or 1 value at each clock edge from reset onward. They also assume that subvl matters only in a cycle where an advance is the selected request. The stimulus drives every input to a defined value from time zero on the falling edge, and holds it through reset. It mixes directed cases with random ones that deliberately collide requests, so that the priority order is exercised while every input stays defined.

// File: rtl/vls_pkg.sv
// Shared widths and the packed live-word type for the loop state unit.
// Assumes the first struct member lands on the most significant bits.
package vls_pkg;
    parameter int unsigned LEN_W   = 7;
    parameter int unsigned MAX_LEN = 64;
    parameter int unsigned SUB_W   = 2;
    parameter int unsigned MAX_SUB = 4;
    parameter int unsigned SEL_W   = 10;
    parameter int unsigned EN_W    = 5;
    parameter int unsigned HINT_W  = 7;
    parameter int unsigned WORD_W  = 64;
    localparam int unsigned RSV_W  = WORD_W - 4*LEN_W - 2*SUB_W - SEL_W - EN_W - HINT_W - 2;
    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);
    localparam logic [SUB_W:0]   SUB_CAP = (SUB_W+1)'(MAX_SUB);

    typedef struct packed {
        logic [LEN_W-1:0]  maxvl;
        logic [LEN_W-1:0]  vl;
        logic [LEN_W-1:0]  srcstep;
        logic [LEN_W-1:0]  dststep;
        logic [SUB_W-1:0]  dsub;
        logic [SUB_W-1:0]  ssub;
        logic [SEL_W-1:0]  rsel;
        logic [EN_W-1:0]   ren;
        logic [RSV_W-1:0]  rsvd;
        logic [HINT_W-1:0] hint;
        logic              persist;
        logic              vfirst;
    } vstate_t;
endpackage

// File: rtl/vls_wrchk.sv
// Range check and VL clamp for a full-word write.
// Assumes the caller ignores nxt whenever bad is set.
module vls_wrchk
    import vls_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output vstate_t           nxt,
    output logic              bad
);
    vstate_t w;
    assign w = vstate_t'(word);

    // Flag out-of-range fields and cap VL at MVL.
    always_comb begin
        bad = (w.srcstep >= LEN_CAP) || (w.dststep >= LEN_CAP) ||
              (w.vl > LEN_CAP) || (w.maxvl > LEN_CAP);
        nxt = w;
        if (w.vl > w.maxvl) nxt.vl = w.maxvl;
    end
endmodule

// File: rtl/vls_setlen.sv
// Computes the word after a set-length request.
// Assumes the caller ignores nxt whenever bad is set.
module vls_setlen
    import vls_pkg::*;
(
    input  vstate_t          cur,
    input  logic [LEN_W:0]   req_len,
    input  logic [LEN_W-1:0] req_mvl,
    output vstate_t          nxt,
    output logic             bad
);
    logic [LEN_W-1:0] new_vl;

    // Pick min(length, MVL), clear the steps and drop persist on any change.
    always_comb begin
        bad    = (req_mvl == '0) || (req_mvl > LEN_CAP);
        new_vl = (req_len > {1'b0, req_mvl}) ? req_mvl : req_len[LEN_W-1:0];
        nxt         = cur;
        nxt.maxvl   = req_mvl;
        nxt.vl      = new_vl;
        nxt.srcstep = '0;
        nxt.dststep = '0;
        nxt.dsub    = '0;
        nxt.ssub    = '0;
        if ((new_vl != cur.vl) || (req_mvl != cur.maxvl)) nxt.persist = 1'b0;
    end
endmodule

// File: rtl/vls_stepper.sv
// Advances the substep (inner) and element step (outer) counters.
// Assumes go is already gated by the vertical-first mode selection.
module vls_stepper
    import vls_pkg::*;
(
    input  vstate_t        cur,
    input  logic [SUB_W:0] subvl,
    input  logic           go,
    output vstate_t        nxt,
    output logic           done,
    output logic           bad
);
    logic [SUB_W-1:0] sub_n;
    logic             last_sub;

    assign last_sub = ({1'b0, cur.dsub} == (subvl - 1'b1));

    // Step the counters once, wrapping the whole loop at VL-1.
    always_comb begin
        bad   = go && ((subvl == '0) || (subvl > SUB_CAP));
        nxt   = cur;
        done  = 1'b0;
        sub_n = cur.dsub + 1'b1;
        if (go && !bad && (cur.vl != '0)) begin
            if (last_sub) begin
                sub_n = '0;
                if (cur.dststep == cur.vl - 1'b1) begin
                    nxt.srcstep = '0;
                    nxt.dststep = '0;
                    done        = 1'b1;
                end else begin
                    nxt.srcstep = cur.srcstep + 1'b1;
                    nxt.dststep = cur.dststep + 1'b1;
                end
            end
            nxt.dsub = sub_n;
            nxt.ssub = sub_n;
        end
    end
endmodule

// File: rtl/vls_core.sv
// Loop state unit top: live word, save copy and link copy, fixed request
// priority. Assumes one request class wins per cycle; the others are dropped.
module vls_core
    import vls_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              setvl_en,
    input  logic [LEN_W:0]    setvl_len,
    input  logic [LEN_W-1:0]  setvl_mvl,
    input  logic              elem_adv,
    input  logic              step_req,
    input  logic [SUB_W:0]    subvl,
    input  logic              exc_enter,
    input  logic              exc_return,
    input  logic              link_swap,
    output logic [WORD_W-1:0] state_o,
    output logic [WORD_W-1:0] save_o,
    output logic [WORD_W-1:0] link_o,
    output logic              illegal_o,
    output logic              done_o,
    output logic              active_o
);
    vstate_t st_q, sr_q, lk_q;
    vstate_t wr_nxt, sl_nxt, sp_nxt;
    logic    wr_bad, sl_bad, sp_bad, sp_done, adv_go;
    logic    ill_q, done_q;

    assign adv_go = st_q.vfirst ? step_req : elem_adv;

    vls_wrchk u_wr (.word(wr_data), .nxt(wr_nxt), .bad(wr_bad));

    vls_setlen u_sl (.cur(st_q), .req_len(setvl_len), .req_mvl(setvl_mvl),
                     .nxt(sl_nxt), .bad(sl_bad));

    vls_stepper u_sp (.cur(st_q), .subvl(subvl), .go(adv_go),
                      .nxt(sp_nxt), .done(sp_done), .bad(sp_bad));

    // Apply the highest-priority request and register the pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= '0;
            sr_q   <= '0;
            lk_q   <= '0;
            ill_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            ill_q  <= 1'b0;
            done_q <= 1'b0;
            if (exc_enter) begin
                sr_q <= st_q;
            end else if (exc_return) begin
                st_q <= sr_q;
            end else if (link_swap) begin
                st_q <= lk_q;
                lk_q <= st_q;
            end else if (wr_en) begin
                if (wr_bad) ill_q <= 1'b1;
                else        st_q  <= wr_nxt;
            end else if (setvl_en) begin
                if (sl_bad) ill_q <= 1'b1;
                else        st_q  <= sl_nxt;
            end else if (adv_go) begin
                if (sp_bad) ill_q <= 1'b1;
                else begin
                    st_q   <= sp_nxt;
                    done_q <= sp_done;
                end
            end
        end
    end

    assign state_o   = st_q;
    assign save_o    = sr_q;
    assign link_o    = lk_q;
    assign illegal_o = ill_q;
    assign done_o    = done_q;
    assign active_o  = (st_q != '0);

    AST_VL_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vl <= st_q.maxvl); // R3

    AST_ILLEGAL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (st_q == $past(st_q))); // R4

    AST_SAVE_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(exc_enter)) |->
        ((save_o == $past(state_o)) && (st_q == $past(st_q)))); // R10

    AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((st_q.srcstep == '0) && (st_q.dststep == '0) && (st_q.dsub == '0))); // R7

    AST_VFIRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(st_q.vfirst) && $past(elem_adv) && !$past(step_req) &&
         !$past(exc_enter || exc_return || link_swap || wr_en || setvl_en))
        |-> (st_q == $past(st_q))); // R6
endmodule

// File: tb/sim_vls_core.sv
// Bench for vls_core: a behavioural reference model compared on every clock,
// plus directed checks on the corner cases.
module sim_vls_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        setvl_en = 1'b0;
    logic [7:0]  setvl_len = '0;
    logic [6:0]  setvl_mvl = '0;
    logic        elem_adv = 1'b0;
    logic        step_req = 1'b0;
    logic [2:0]  subvl = 3'd1;
    logic        exc_enter = 1'b0;
    logic        exc_return = 1'b0;
    logic        link_swap = 1'b0;
    logic [63:0] state_o, save_o, link_o;
    logic        illegal_o, done_o, active_o;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    vls_core u0 (.*);

    // Field access with field position counted from the most significant bit.
    function automatic int fget(logic [63:0] w, int s, int n);
        return int'((w >> (64 - s - n)) & ((64'd1 << n) - 64'd1));
    endfunction
    function automatic logic [63:0] fset(logic [63:0] w, int s, int n, int v);
        logic [63:0] m;
        m = ((64'd1 << n) - 64'd1) << (64 - s - n);
        return (w & ~m) | ((64'(v) << (64 - s - n)) & m);
    endfunction
    function automatic logic [63:0] mk(int mvl, int vl, int src, int dst, int sub, int pers, int vf);
        logic [63:0] w = '0;
        w = fset(w, 0, 7, mvl);  w = fset(w, 7, 7, vl);
        w = fset(w, 14, 7, src); w = fset(w, 21, 7, dst);
        w = fset(w, 28, 2, sub); w = fset(w, 30, 2, sub);
        w = fset(w, 62, 1, pers); w = fset(w, 63, 1, vf);
        return w;
    endfunction

    // Reference model state.
    logic [63:0] m_st = '0, m_sr = '0, m_lk = '0;
    bit m_ill = 1'b0, m_done = 1'b0;

    // Reference model update on every rising edge.
    always @(posedge clk) begin
        logic [63:0] t;
        int vl, mvl, src, dst, ds, nvl, pers, sv;
        m_ill = 1'b0; m_done = 1'b0;
        if (!rst_n) begin
            m_st = '0; m_sr = '0; m_lk = '0;
        end else if (exc_enter) m_sr = m_st;
        else if (exc_return) m_st = m_sr;
        else if (link_swap) begin t = m_st; m_st = m_lk; m_lk = t; end
        else if (wr_en) begin
            mvl = fget(wr_data, 0, 7); vl = fget(wr_data, 7, 7);
            src = fget(wr_data, 14, 7); dst = fget(wr_data, 21, 7);
            if (src >= 64 || dst >= 64 || vl > 64 || mvl > 64) m_ill = 1'b1;
            else m_st = fset(wr_data, 7, 7, (vl > mvl) ? mvl : vl);
        end else if (setvl_en) begin
            mvl = int'(setvl_mvl);
            if (mvl == 0 || mvl > 64) m_ill = 1'b1;
            else begin
                nvl  = (int'(setvl_len) < mvl) ? int'(setvl_len) : mvl;
                pers = fget(m_st, 62, 1);
                if (nvl != fget(m_st, 7, 7) || mvl != fget(m_st, 0, 7)) pers = 0;
                m_st = fset(m_st, 0, 7, mvl);  m_st = fset(m_st, 7, 7, nvl);
                m_st = fset(m_st, 14, 7, 0);   m_st = fset(m_st, 21, 7, 0);
                m_st = fset(m_st, 28, 2, 0);   m_st = fset(m_st, 30, 2, 0);
                m_st = fset(m_st, 62, 1, pers);
            end
        end else if (fget(m_st, 63, 1) != 0 ? step_req : elem_adv) begin
            sv = int'(subvl);
            vl = fget(m_st, 7, 7);
            if (sv < 1 || sv > 4) m_ill = 1'b1;
            else if (vl != 0) begin
                ds = fget(m_st, 28, 2); src = fget(m_st, 14, 7); dst = fget(m_st, 21, 7);
                if (ds == sv - 1) begin
                    ds = 0;
                    if (dst == vl - 1) begin src = 0; dst = 0; m_done = 1'b1; end
                    else begin src = (src + 1) % 128; dst = (dst + 1) % 128; end
                end else ds = (ds + 1) % 4;
                m_st = fset(m_st, 14, 7, src); m_st = fset(m_st, 21, 7, dst);
                m_st = fset(m_st, 28, 2, ds);  m_st = fset(m_st, 30, 2, ds);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare every output against the model.
    task automatic cmp_all();
        chk(state_o == m_st, "R12 live word", state_o, m_st);
        chk(save_o == m_sr, "R10 save word", save_o, m_sr);
        chk(link_o == m_lk, "R11 link word", link_o, m_lk);
        chk(illegal_o == m_ill, "R4 illegal pulse", 64'(illegal_o), 64'(m_ill));
        chk(done_o == m_done, "R7 done pulse", 64'(done_o), 64'(m_done));
        chk(active_o == (m_st != '0), "R9 active flag", 64'(active_o), 64'(m_st != '0));
    endtask

    // One clock: let the edge pass, compare, clear the request inputs.
    task automatic cyc();
        @(negedge clk);
        cmp_all();
        wr_en = 1'b0; setvl_en = 1'b0; elem_adv = 1'b0; step_req = 1'b0;
        exc_enter = 1'b0; exc_return = 1'b0; link_swap = 1'b0;
    endtask

    task automatic do_wr(input logic [63:0] w); wr_en = 1'b1; wr_data = w; cyc(); endtask
    task automatic do_sl(input int len, input int mvl);
        setvl_en = 1'b1; setvl_len = 8'(len); setvl_mvl = 7'(mvl); cyc();
    endtask
    task automatic do_adv(input int sv); elem_adv = 1'b1; subvl = 3'(sv); cyc(); endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc();
        chk(state_o == '0 && save_o == '0 && link_o == '0, "R13 reset words", state_o, '0);
        chk(!illegal_o && !done_o && !active_o, "R13 reset pulses", {61'd0, illegal_o, done_o, active_o}, '0);

        do_wr(64'h0204_0000_0000_0000);
        chk(state_o == 64'h0204_0000_0000_0000, "R1 layout mvl=1 vl=1", state_o, 64'h0204_0000_0000_0000);
        chk(active_o, "R9 active on nonzero", 64'(active_o), 64'd1);

        do_sl(5, 8);
        chk(fget(state_o, 0, 7) == 8 && fget(state_o, 7, 7) == 5, "R2 setvl 5/8", state_o, mk(8, 5, 0, 0, 0, 0, 0));
        do_sl(100, 8);
        chk(fget(state_o, 7, 7) == 8, "R2 setvl capped", 64'(fget(state_o, 7, 7)), 64'd8);
        do_sl(3, 0);
        chk(illegal_o && fget(state_o, 7, 7) == 8, "R4 setvl mvl=0", state_o, mk(8, 8, 0, 0, 0, 0, 0));
        do_wr(mk(10, 20, 0, 0, 0, 0, 0));
        chk(fget(state_o, 7, 7) == 10, "R3 write vl clamp", 64'(fget(state_o, 7, 7)), 64'd10);
        do_wr(mk(10, 5, 64, 0, 0, 0, 0));
        chk(illegal_o && state_o == mk(10, 10, 0, 0, 0, 0, 0), "R4 write src=64", state_o, mk(10, 10, 0, 0, 0, 0, 0));

        do_sl(2, 4);
        do_adv(2);
        chk(state_o == mk(4, 2, 0, 0, 1, 0, 0), "R7 step 1", state_o, mk(4, 2, 0, 0, 1, 0, 0));
        do_adv(2);
        chk(state_o == mk(4, 2, 1, 1, 0, 0, 0), "R7 step 2", state_o, mk(4, 2, 1, 1, 0, 0, 0));
        do_adv(2);
        do_adv(2);
        chk(state_o == mk(4, 2, 0, 0, 0, 0, 0) && done_o, "R7 wrap and done", state_o, mk(4, 2, 0, 0, 0, 0, 0));
        do_adv(5);
        chk(illegal_o && state_o == mk(4, 2, 0, 0, 0, 0, 0), "R5 subvl=5", state_o, mk(4, 2, 0, 0, 0, 0, 0));

        do_wr(mk(3, 3, 0, 0, 0, 0, 1));
        do_adv(1);
        chk(state_o == mk(3, 3, 0, 0, 0, 0, 1), "R6 elem_adv ignored", state_o, mk(3, 3, 0, 0, 0, 0, 1));
        step_req = 1'b1; subvl = 3'd1; cyc();
        chk(state_o == mk(3, 3, 1, 1, 0, 0, 1), "R6 step_req advances", state_o, mk(3, 3, 1, 1, 0, 0, 1));

        do_wr(mk(3, 3, 0, 0, 0, 1, 0));
        do_sl(3, 3);
        chk(fget(state_o, 62, 1) == 1, "R8 persist kept", state_o, mk(3, 3, 0, 0, 0, 1, 0));
        do_sl(2, 3);
        chk(fget(state_o, 62, 1) == 0, "R8 persist cleared", state_o, mk(3, 2, 0, 0, 0, 0, 0));

        exc_enter = 1'b1; elem_adv = 1'b1; subvl = 3'd1; cyc();
        chk(save_o == mk(3, 2, 0, 0, 0, 0, 0) && state_o == save_o, "R12 enter beats advance", save_o, mk(3, 2, 0, 0, 0, 0, 0));
        do_sl(7, 9);
        exc_return = 1'b1; cyc();
        chk(state_o == mk(3, 2, 0, 0, 0, 0, 0), "R10 return restores", state_o, mk(3, 2, 0, 0, 0, 0, 0));
        link_swap = 1'b1; cyc();
        chk(state_o == '0 && link_o == mk(3, 2, 0, 0, 0, 0, 0) && !active_o, "R11 swap out", link_o, mk(3, 2, 0, 0, 0, 0, 0));
        link_swap = 1'b1; cyc();
        chk(state_o == mk(3, 2, 0, 0, 0, 0, 0) && link_o == '0, "R11 swap back", state_o, mk(3, 2, 0, 0, 0, 0, 0));

        // Random phase with colliding requests.
        for (int i = 0; i < 3000; i++) begin
            int op;
            op = int'($urandom_range(0, 99));
            exc_enter  = (op < 3);
            exc_return = (op >= 3 && op < 6);
            link_swap  = (op >= 6 && op < 9);
            wr_en      = (op >= 9 && op < 20) || ($urandom_range(0, 15) == 0);
            setvl_en   = (op >= 20 && op < 30) || ($urandom_range(0, 15) == 0);
            elem_adv   = (op >= 30) || ($urandom_range(0, 3) == 0);
            step_req   = ($urandom_range(0, 1) == 1);
            subvl      = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(0, 7)) : 3'($urandom_range(1, 4));
            wr_data    = {$urandom, $urandom};
            if ($urandom_range(0, 3) != 0)
                wr_data = mk(int'($urandom_range(0, 66)), int'($urandom_range(0, 66)),
                             int'($urandom_range(0, 64)), int'($urandom_range(0, 64)),
                             int'($urandom_range(0, 3)), int'($urandom_range(0, 1)),
                             int'($urandom_range(0, 1)));
            setvl_len  = 8'($urandom_range(0, 70));
            setvl_mvl  = 7'($urandom_range(0, 66));
            cyc();
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R13 actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule